// File: doc/BRIEF.md
# Per-Pixel Integration-Time Calculator

This block turns pixel firing events into luminance values without an analog-to-digital converter. A pixel fires when it has collected enough light, and the event reaches the block as a pixel address plus a timestamp from a free-running counter. For each pixel the block keeps two values in two inferred RAMs:

- **Reset-instant store:** the instant at which the pixel last restarted.
- **Image store:** the integration time the pixel last produced.

The moment a pixel fires is also the moment it restarts. Each event therefore works in three steps:

1. Look up the pixel's previous restart instant.
2. Subtract it from the event timestamp.
3. Write the difference into the image store and the event timestamp into the reset-instant store.

A separate registered read port lets a display engine read the image store at any time. Events are taken through a valid/ready handshake. After reset, the block first clears both stores over one full sweep of the address space, holding ready low. Clearing the reset-instant store to zero makes every pixel count from one common start instant. The block then accepts events one at a time: an accepted event occupies one further cycle for the lookup result and the write-back.

Top module: `pix_itime_unit`

## Requirements
- R1: After reset is released, `evt_ready` stays low for exactly 2^ADDR_W clock edges while both stores are cleared, then goes high.
- R2: Once the clearing sweep ends, every address of the image store reads 0 on the display port.
- R3: An event is accepted on a clock edge where `evt_valid` and `evt_ready` are both high. `evt_ready` is low for exactly the one following cycle and is high again after that.
- R4: The value stored for a pixel is the event timestamp minus that pixel's stored reset instant, taken modulo 2^TS_W. The first event of a pixel after reset subtracts 0.
- R5: Every accepted event's timestamp becomes that pixel's new reset instant, so the next event of the same pixel measures from it. An event repeating the stored instant yields 0.
- R6: When the timestamp counter has wrapped once between two events of a pixel, so that the new timestamp is numerically smaller, the result is still the true elapsed count: for example 0x0010 after 0xFFF0 gives 0x0020 with TS_W=16.
- R7: An event changes only the entries of its own pixel. All other pixels keep their image values.
- R8: The display port is registered, with one cycle of latency from `rd_addr`. The new value of a pixel appears on `rd_data` at the second clock edge after the acceptance edge. A read sampled at the first edge after acceptance still returns the previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | Event offered |
| evt_ready | output | 1 | Block can take an event this cycle |
| evt_addr | input | ADDR_W | Address of the firing pixel |
| evt_ts | input | TS_W | Timestamp of the firing event |
| rd_addr | input | ADDR_W | Display read address |
| rd_data | output | TS_W | Integration time of the pixel at `rd_addr`, one cycle later |

## Verification
The assertions check on every cycle that the handshake behaves as specified:

- An acceptance always drops ready for one cycle and is followed by exactly one write-back.
- The write-back stores the accepted timestamp as the new reset instant.
- The stored difference plus the old reset instant equals that timestamp, modulo 2^TS_W.

Only the bench's scenarios can show the remaining behaviour:

- The length of the clearing sweep and the all-zero image after it.
- Chains of events on one pixel, a counter wrap, and an equal timestamp.
- Pixel isolation, checked by a full sweep of the image.
- The old-then-new order seen on the display port around a write-back.

// File: rtl/pix_itime_pkg.sv
package pix_itime_pkg;
  typedef enum logic [1:0] {
    SEQ_INIT = 2'd0,
    SEQ_IDLE = 2'd1,
    SEQ_CALC = 2'd2
  } seq_state_e;
endpackage

// File: rtl/pix_stamp_ram.sv
module pix_stamp_ram #(
  parameter int WIDTH  = 16,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WIDTH-1:0]  wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WIDTH-1:0]  rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WIDTH-1:0] mem [DEPTH];

  // write first in source order, read returns the value held before the edge
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/pix_event_seq.sv
module pix_event_seq
  import pix_itime_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int TS_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_valid,
  input  logic [ADDR_W-1:0] evt_addr,
  input  logic [TS_W-1:0]   evt_ts,
  output logic              evt_ready,
  output logic              init_busy,
  output logic              commit_fire,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [TS_W-1:0]   ts_q
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

  seq_state_e        state_q;
  logic [ADDR_W-1:0] sweep_q;
  logic [ADDR_W-1:0] addr_q;
  logic              accept;

  assign accept = evt_valid && evt_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SEQ_INIT;
      sweep_q <= '0;
      addr_q  <= '0;
      ts_q    <= '0;
    end else begin
      case (state_q)
        SEQ_INIT: begin
          sweep_q <= sweep_q + 1'b1;
          if (sweep_q == LAST_ADDR) state_q <= SEQ_IDLE;
        end
        SEQ_IDLE: begin
          if (evt_valid) begin
            addr_q  <= evt_addr;
            ts_q    <= evt_ts;
            state_q <= SEQ_CALC;
          end
        end
        SEQ_CALC: state_q <= SEQ_IDLE;
        default:  state_q <= SEQ_INIT;
      endcase
    end
  end

  assign evt_ready   = (state_q == SEQ_IDLE);
  assign init_busy   = (state_q == SEQ_INIT);
  assign commit_fire = (state_q == SEQ_CALC);
  assign wr_en       = init_busy || commit_fire;
  assign wr_addr     = init_busy ? sweep_q : addr_q;

  // R3: an accepted event makes the block busy on the next cycle
  assert_busy_after_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !evt_ready);

  // R3: every write-back is caused by an acceptance one cycle earlier
  assert_commit_follows_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    commit_fire |-> $past(accept));

  // R3: after the write-back the block is ready again
  assert_ready_after_commit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    commit_fire |=> evt_ready);
endmodule

// File: rtl/pix_itime_unit.sv
module pix_itime_unit #(
  parameter int ADDR_W = 6,
  parameter int TS_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_valid,
  output logic              evt_ready,
  input  logic [ADDR_W-1:0] evt_addr,
  input  logic [TS_W-1:0]   evt_ts,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [TS_W-1:0]   rd_data
);
  // elapsed count between two counter samples, one wrap tolerated
  function automatic logic [TS_W-1:0] itime_diff(input logic [TS_W-1:0] now_ts,
                                                 input logic [TS_W-1:0] last_ts);
    return now_ts - last_ts;
  endfunction

  logic              init_busy;
  logic              commit_fire;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [TS_W-1:0]   ts_q;
  logic [TS_W-1:0]   rst_rdata;
  logic [TS_W-1:0]   rst_wdata;
  logic [TS_W-1:0]   itm_wdata;

  pix_event_seq #(.ADDR_W(ADDR_W), .TS_W(TS_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_valid  (evt_valid),
    .evt_addr   (evt_addr),
    .evt_ts     (evt_ts),
    .evt_ready  (evt_ready),
    .init_busy  (init_busy),
    .commit_fire(commit_fire),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .ts_q       (ts_q)
  );

  assign rst_wdata = init_busy ? '0 : ts_q;
  assign itm_wdata = init_busy ? '0 : itime_diff(ts_q, rst_rdata);

  // reset-instant store: looked up on the acceptance edge
  pix_stamp_ram #(.WIDTH(TS_W), .ADDR_W(ADDR_W)) u_rst_mem (
    .clk  (clk),
    .we   (wr_en),
    .waddr(wr_addr),
    .wdata(rst_wdata),
    .raddr(evt_addr),
    .rdata(rst_rdata)
  );

  // image store: read by the display side
  pix_stamp_ram #(.WIDTH(TS_W), .ADDR_W(ADDR_W)) u_img_mem (
    .clk  (clk),
    .we   (wr_en),
    .waddr(wr_addr),
    .wdata(itm_wdata),
    .raddr(rd_addr),
    .rdata(rd_data)
  );

  // R5: the write-back stores the accepted timestamp as the new reset instant
  assert_reset_instant_is_ts_R5: assert property (@(posedge clk) disable iff (!rst_n)
    commit_fire |-> rst_wdata == $past(evt_ts));

  // R4: stored difference plus old instant gives back the new instant
  assert_itime_sum_R4: assert property (@(posedge clk) disable iff (!rst_n)
    commit_fire |-> TS_W'(itm_wdata + rst_rdata) == $past(evt_ts));
endmodule

// File: tb/pix_itime_unit_bench.sv
module pix_itime_unit_bench;
  localparam int ADDR_W = 6;
  localparam int TS_W   = 16;
  localparam int DEPTH  = 1 << ADDR_W;

  typedef struct {
    int    addr;
    int    exp_val;
    int    old_val;
    string tag;
  } item_t;

  logic              clk = 0;
  logic              rst_n = 0;
  logic              evt_valid = 0;
  logic              evt_ready;
  logic [ADDR_W-1:0] evt_addr = '0;
  logic [TS_W-1:0]   evt_ts = '0;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic [TS_W-1:0]   rd_data;

  int    checks = 0;
  int    failures = 0;
  int    last_rst [DEPTH];
  int    img [DEPTH];
  item_t sb_q [$];
  bit    mon_busy = 0;

  always #5 clk = ~clk;

  pix_itime_unit #(.ADDR_W(ADDR_W), .TS_W(TS_W)) u_pix_itime_unit (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_ready(evt_ready),
    .evt_addr(evt_addr), .evt_ts(evt_ts), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // elapsed count written as a case split rather than modular subtraction
  function automatic int elapsed(input int now_ts, input int prev_ts);
    if (now_ts >= prev_ts) return now_ts - prev_ts;
    return now_ts + (1 << TS_W) - prev_ts;
  endfunction

  task automatic send(input int a, input int t, input string tag);
    item_t it;
    @(negedge clk);
    while (!evt_ready) @(negedge clk);
    evt_valid = 1;
    evt_addr  = ADDR_W'(a);
    evt_ts    = TS_W'(t);
    it.addr    = a;
    it.old_val = img[a];
    it.exp_val = elapsed(t, last_rst[a]);
    it.tag     = tag;
    last_rst[a] = t;
    img[a]      = it.exp_val;
    @(negedge clk);
    evt_valid = 0;
    sb_q.push_back(it);
    check("R3 ready low after accept", int'(evt_ready), 0);
    @(negedge clk);
    check("R3 ready back high", int'(evt_ready), 1);
    wait (sb_q.size() == 0 && !mon_busy);
  endtask

  // monitor: pops each expected item and watches the display port
  initial begin
    item_t it;
    forever begin
      wait (sb_q.size() > 0);
      mon_busy = 1;
      it = sb_q.pop_front();
      rd_addr = ADDR_W'(it.addr);
      @(posedge clk);
      @(negedge clk);
      check("R8 old value at first edge", int'(rd_data), it.old_val);
      @(posedge clk);
      @(negedge clk);
      check(it.tag, int'(rd_data), it.exp_val);
      mon_busy = 0;
    end
  end

  task automatic read_pix(input int a, input int exp, input string req);
    @(negedge clk);
    rd_addr = ADDR_W'(a);
    @(posedge clk);
    @(negedge clk);
    check(req, int'(rd_data), exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int low_cnt;
    for (int i = 0; i < DEPTH; i++) begin
      last_rst[i] = 0;
      img[i] = 0;
    end
    repeat (3) @(negedge clk);
    check("R1 ready low in reset", int'(evt_ready), 0);
    rst_n = 1;
    low_cnt = 0;
    while (!evt_ready) begin
      @(negedge clk);
      low_cnt++;
    end
    check("R1 clearing sweep length", low_cnt, DEPTH);
    for (int i = 0; i < DEPTH; i++) read_pix(i, 0, "R2 cleared image");

    send(5, 100, "R4 first event subtracts zero");
    send(5, 350, "R5 measures from previous event");
    send(9, 1000, "R4 other pixel");
    send(3, 16'hFFF0, "R4 near top of counter");
    send(3, 16'h0010, "R6 counter wrap");
    send(5, 350, "R5 equal timestamp gives zero");
    send(0, 7, "R4 lowest address");
    send(63, 40000, "R4 highest address");
    send(9, 1500, "R5 second event pixel 9");

    for (int i = 0; i < DEPTH; i++) read_pix(i, img[i], "R7 image sweep");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule